// File: doc/BRIEF.md
# System Control Register Bank

This block holds the privileged control registers of a 32-bit processor core. The pipeline reaches it through move-to and move-from accesses. Each access names a register with a 5-bit number and a 3-bit select. Reads are combinational on the current address. Writes take effect at the clock edge.

Every writable register has two masks. A load mask chooses the bits that come from the write data. A keep mask chooses the bits that hold their old value. All other bits are cleared. The block also keeps four privilege flags: user, exception level, error level and debug mode. These flags are stored outside the registers and are merged into the read values of Status and Debug.

The block produces two side effects:
- A level hard-interrupt request, which is raised or dropped only on an edge of the interrupt-enable bit.
- A one-cycle translation flush request, which fires when the address-space ID changes.

The timer, the random-index generator, the load-linked address and the faulting address are kept elsewhere. They arrive as plain inputs.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, every stored register reads 0 except Config (register 16, select 0), which reads the `CFG0_RESET` parameter. The four mode flags, `hardIrq` and `flushReq` are all 0.
- R2: Writes pass through a fixed mask per register:
  - EntryLo0 and EntryLo1 (2, 3): 0x3FFFFFFF
  - PageMask (5): 0x01FFE000
  - Wired (6): 0x0000000F
  - EntryHi (10): 0xFFFFE0FF
  - Status (12): 0xFA78FF01
  - WatchHi (19): 0x40FF0FF8
  - TagLo (28, select 0): 0xFFFFFCF6
  - EPC (14), WatchLo (18), DEPC (24), ErrorEPC (30) and DESAVE (31): all bits
- R3: Some registers keep fields across a write:
  - Index (0) keeps bit 31 and loads bits 3:0.
  - Context (4) keeps bits 31:23 and loads bits 22:4.
  - Cause (13) keeps 0xB000F87C and loads only bits 9:8. Its bits 15:10 always read the `irqLines` input.
  - Config (16, select 0) keeps 0xFE17FF80 and loads bit 0.
  - Debug (23) keeps 0x8C03FC1F and loads 0x13300120.
- R4: A non-zero select is honoured only for registers 16 and 28. Any other register with a non-zero select reads 0 and ignores writes. Register 16 select 1 reads the `CFG1_VAL` parameter. Register 28 select 1 reads 0. Both select-1 registers ignore writes.
- R5: Some registers come from inputs or parameters and ignore writes:
  - 1 reads `randomVal`
  - 8 reads `badVaddr`
  - 9 reads `countVal`
  - 11 reads `compareVal`
  - 15 reads `PRID_VAL`
  - 17 reads `llAddr` shifted right by 4
  
  Register numbers 7, 20, 21, 22, 25, 26, 27 and 29 read 0 and ignore writes.
- R6: A Status write copies write-data bit 4 to `userMode`, bit 2 to `errLevel` and bit 1 to `excLevel`. A Status read ORs these flags back into bits 4, 2 and 1.
- R7: A Debug write copies write-data bit 30 to `debugMode`. A Debug read ORs the flag into bit 30.
- R8: `hardIrq` rises after a Status write that meets all of these conditions:
  - it moves bit 0 (interrupt enable) from 0 to 1;
  - the written bits 1 and 2 are both 0;
  - `debugMode` is 0;
  - the new Status bits 15:8 ANDed with the Cause read bits 15:8 are non-zero.
- R9: `hardIrq` falls after a Status write that moves bit 0 from 1 to 0. Any other access leaves it unchanged.
- R10: An EntryHi write that changes bits 7:0 sets `flushReq` for exactly the cycle after the write edge. An EntryHi write that leaves bits 7:0 unchanged does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Move-to strobe for the addressed register |
| accReg | input | 5 | Register number of the access |
| accSel | input | 3 | Select of the access |
| wrData | input | 32 | Move-to data |
| rdData | output | 32 | Move-from data for the addressed register (combinational) |
| irqLines | input | 6 | Hardware interrupt lines, visible as Cause bits 15:10 |
| randomVal | input | 32 | Random index from the external generator |
| countVal | input | 32 | Timer count value |
| compareVal | input | 32 | Timer compare value |
| badVaddr | input | 32 | Last faulting virtual address |
| llAddr | input | 32 | Load-linked physical address |
| userMode | output | 1 | User-mode flag |
| excLevel | output | 1 | Exception-level flag |
| errLevel | output | 1 | Error-level flag |
| debugMode | output | 1 | Debug-mode flag |
| hardIrq | output | 1 | Hard-interrupt request (level) |
| flushReq | output | 1 | Translation flush request (one-cycle pulse) |

## Verification
The assertions are checked on every cycle. They cover the following:
- Only one register is written per cycle, and an illegal select never produces a write.
- Index bit 31 and the kept Cause fields never change.
- `flushReq` always follows an EntryHi write.
- An edge on `hardIrq` matches the interrupt-enable state and the privilege flags.

Some behaviour can only be shown by the directed scenarios. These include the actual masked values, the merged flag bits on read, the pass-through registers, and the negative cases where no interrupt or flush should fire: pending masked off, exception level or debug mode set, and an unchanged ID.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int XLEN  = 32;
  localparam int REG_W = 5;
  localparam int SEL_W = 3;

  // Bit positions that neighbours decode
  localparam int ST_IE   = 0;
  localparam int ST_EXL  = 1;
  localparam int ST_ERL  = 2;
  localparam int ST_UM   = 4;
  localparam int IM_LO   = 8;
  localparam int IM_HI   = 15;
  localparam int HWIP_LO = 10;
  localparam int HWIP_W  = IM_HI - HWIP_LO + 1;
  localparam int DBG_DM  = 30;
  localparam int ASID_W  = 8;
  localparam int LL_SHIFT = 4;

  typedef enum logic [4:0] {
    SL_INDEX, SL_ENTLO0, SL_ENTLO1, SL_CONTEXT, SL_PGMASK, SL_WIRED,
    SL_ENTHI, SL_STATUS, SL_CAUSE, SL_EPC, SL_CONFIG0, SL_WATCHLO,
    SL_WATCHHI, SL_DEBUG, SL_DEPC, SL_TAGLO, SL_ERREPC, SL_DESAVE
  } slot_e;

  localparam int NSLOT = 18;

  typedef enum logic [3:0] {
    RS_ZERO, RS_SLOT, RS_RANDOM, RS_BADV, RS_COUNT, RS_COMPARE,
    RS_PRID, RS_CFG1, RS_LLADDR
  } rdsrc_e;

  typedef struct packed {
    logic             wr;
    logic [NSLOT-1:0] wrOh;
    slot_e            slot;
    rdsrc_e           rdSrc;
    logic             stWr;
    logic             dbgWr;
    logic             ehiWr;
  } strobe_t;

  function automatic logic [XLEN-1:0] loadMask(slot_e s);
    case (s)
      SL_INDEX:   return 32'h0000_000F;
      SL_ENTLO0,
      SL_ENTLO1:  return 32'h3FFF_FFFF;
      SL_CONTEXT: return 32'h007F_FFF0;
      SL_PGMASK:  return 32'h01FF_E000;
      SL_WIRED:   return 32'h0000_000F;
      SL_ENTHI:   return 32'hFFFF_E0FF;
      SL_STATUS:  return 32'hFA78_FF01;
      SL_CAUSE:   return 32'h0000_0300;
      SL_CONFIG0: return 32'h0000_0001;
      SL_WATCHHI: return 32'h40FF_0FF8;
      SL_DEBUG:   return 32'h1330_0120;
      SL_TAGLO:   return 32'hFFFF_FCF6;
      default:    return '1;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] keepMask(slot_e s);
    case (s)
      SL_INDEX:   return 32'h8000_0000;
      SL_CONTEXT: return 32'hFF80_0000;
      SL_CAUSE:   return 32'hB000_F87C;
      SL_CONFIG0: return 32'hFE17_FF80;
      SL_DEBUG:   return 32'h8C03_FC1F;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] accReg,
  input  logic [SEL_W-1:0] accSel,
  output strobe_t          stb
);

  slot_e  slot;
  rdsrc_e baseSrc;
  rdsrc_e rdSrc;
  logic   selOk;

  always_comb begin
    slot    = SL_INDEX;
    baseSrc = RS_ZERO;
    case (accReg)
      5'd0:  begin slot = SL_INDEX;   baseSrc = RS_SLOT; end
      5'd1:  baseSrc = RS_RANDOM;
      5'd2:  begin slot = SL_ENTLO0;  baseSrc = RS_SLOT; end
      5'd3:  begin slot = SL_ENTLO1;  baseSrc = RS_SLOT; end
      5'd4:  begin slot = SL_CONTEXT; baseSrc = RS_SLOT; end
      5'd5:  begin slot = SL_PGMASK;  baseSrc = RS_SLOT; end
      5'd6:  begin slot = SL_WIRED;   baseSrc = RS_SLOT; end
      5'd8:  baseSrc = RS_BADV;
      5'd9:  baseSrc = RS_COUNT;
      5'd10: begin slot = SL_ENTHI;   baseSrc = RS_SLOT; end
      5'd11: baseSrc = RS_COMPARE;
      5'd12: begin slot = SL_STATUS;  baseSrc = RS_SLOT; end
      5'd13: begin slot = SL_CAUSE;   baseSrc = RS_SLOT; end
      5'd14: begin slot = SL_EPC;     baseSrc = RS_SLOT; end
      5'd15: baseSrc = RS_PRID;
      5'd16: begin
        slot = SL_CONFIG0;
        if (accSel == 3'd0)      baseSrc = RS_SLOT;
        else if (accSel == 3'd1) baseSrc = RS_CFG1;
      end
      5'd17: baseSrc = RS_LLADDR;
      5'd18: begin slot = SL_WATCHLO; baseSrc = RS_SLOT; end
      5'd19: begin slot = SL_WATCHHI; baseSrc = RS_SLOT; end
      5'd23: begin slot = SL_DEBUG;   baseSrc = RS_SLOT; end
      5'd24: begin slot = SL_DEPC;    baseSrc = RS_SLOT; end
      5'd28: begin
        slot = SL_TAGLO;
        if (accSel == 3'd0) baseSrc = RS_SLOT;
      end
      5'd30: begin slot = SL_ERREPC;  baseSrc = RS_SLOT; end
      5'd31: begin slot = SL_DESAVE;  baseSrc = RS_SLOT; end
      default: baseSrc = RS_ZERO;
    endcase
  end

  // A non-zero select is only meaningful for registers 16 and 28
  assign selOk = (accSel == '0) || (accReg == 5'd16) || (accReg == 5'd28);
  assign rdSrc = selOk ? baseSrc : RS_ZERO;

  always_comb begin
    stb.slot  = slot;
    stb.rdSrc = rdSrc;
    stb.wr    = wrEn && (rdSrc == RS_SLOT);
    stb.wrOh  = stb.wr ? (NSLOT'(1) << slot) : '0;
    stb.stWr  = stb.wr && (slot == SL_STATUS);
    stb.dbgWr = stb.wr && (slot == SL_DEBUG);
    stb.ehiWr = stb.wr && (slot == SL_ENTHI);
  end

  AST_SEL_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (accSel != '0 && accReg != 5'd16 && accReg != 5'd28) |-> stb.wrOh == '0); // R4

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.wrOh)); // R2

endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] PRID_VAL   = 32'h0001_8000,
  parameter logic [XLEN-1:0] CFG0_RESET = 32'h8000_8080,
  parameter logic [XLEN-1:0] CFG1_VAL   = 32'h1E19_0C8A
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [XLEN-1:0]   wrData,
  input  logic [HWIP_W-1:0] irqLines,
  input  logic [XLEN-1:0]   randomVal,
  input  logic [XLEN-1:0]   countVal,
  input  logic [XLEN-1:0]   compareVal,
  input  logic [XLEN-1:0]   badVaddr,
  input  logic [XLEN-1:0]   llAddr,
  output logic [XLEN-1:0]   rdData,
  output logic              userMode,
  output logic              excLevel,
  output logic              errLevel,
  output logic              debugMode,
  output logic              hardIrq,
  output logic              flushReq
);

  logic [XLEN-1:0] regQ [NSLOT];
  logic [XLEN-1:0] causeView;
  logic [XLEN-1:0] statusNew;
  logic            pendNew;
  logic            ieRise;
  logic            ieFall;
  logic            asidDiff;
  logic            umQ, exlQ, erlQ, dmQ, irqQ, flushQ;

  // Storage: one register per slot, written through its keep and load masks
  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    localparam logic [XLEN-1:0] KEEP  = keepMask(slot_e'(g));
    localparam logic [XLEN-1:0] LOAD  = loadMask(slot_e'(g));
    localparam logic [XLEN-1:0] RSTV  = (g == int'(SL_CONFIG0)) ? CFG0_RESET : '0;
    always_ff @(posedge clk) begin
      if (!rstN)              regQ[g] <= RSTV;
      else if (stb.wrOh[g])   regQ[g] <= (regQ[g] & KEEP) | (wrData & LOAD);
    end
  end

  assign causeView = {regQ[SL_CAUSE][XLEN-1:IM_HI+1], irqLines, regQ[SL_CAUSE][HWIP_LO-1:0]};
  assign statusNew = wrData & loadMask(SL_STATUS);
  assign pendNew   = |(statusNew[IM_HI:IM_LO] & causeView[IM_HI:IM_LO]);
  assign ieRise    = stb.stWr && !regQ[SL_STATUS][ST_IE] && wrData[ST_IE];
  assign ieFall    = stb.stWr && regQ[SL_STATUS][ST_IE] && !wrData[ST_IE];
  assign asidDiff  = regQ[SL_ENTHI][ASID_W-1:0] != wrData[ASID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      umQ    <= 1'b0;
      exlQ   <= 1'b0;
      erlQ   <= 1'b0;
      dmQ    <= 1'b0;
      irqQ   <= 1'b0;
      flushQ <= 1'b0;
    end else begin
      if (stb.stWr) begin
        umQ  <= wrData[ST_UM];
        exlQ <= wrData[ST_EXL];
        erlQ <= wrData[ST_ERL];
      end
      if (stb.dbgWr) dmQ <= wrData[DBG_DM];
      // Privilege flags are taken from the new write data, debug from its current value
      if (ieRise && !wrData[ST_EXL] && !wrData[ST_ERL] && !dmQ && pendNew)
        irqQ <= 1'b1;
      else if (ieFall)
        irqQ <= 1'b0;
      flushQ <= stb.ehiWr && asidDiff;
    end
  end

  always_comb begin
    case (stb.rdSrc)
      RS_SLOT: begin
        case (stb.slot)
          SL_STATUS: rdData = regQ[SL_STATUS]
                              | (XLEN'(umQ)  << ST_UM)
                              | (XLEN'(erlQ) << ST_ERL)
                              | (XLEN'(exlQ) << ST_EXL);
          SL_CAUSE:  rdData = causeView;
          SL_DEBUG:  rdData = regQ[SL_DEBUG] | (XLEN'(dmQ) << DBG_DM);
          default:   rdData = regQ[stb.slot];
        endcase
      end
      RS_RANDOM:  rdData = randomVal;
      RS_BADV:    rdData = badVaddr;
      RS_COUNT:   rdData = countVal;
      RS_COMPARE: rdData = compareVal;
      RS_PRID:    rdData = PRID_VAL;
      RS_CFG1:    rdData = CFG1_VAL;
      RS_LLADDR:  rdData = llAddr >> LL_SHIFT;
      default:    rdData = '0;
    endcase
  end

  assign userMode  = umQ;
  assign excLevel  = exlQ;
  assign errLevel  = erlQ;
  assign debugMode = dmQ;
  assign hardIrq   = irqQ;
  assign flushReq  = flushQ;

  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    flushQ |-> $past(stb.ehiWr)); // R10

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> (regQ[SL_STATUS][ST_IE] && !exlQ && !erlQ && !dmQ)); // R8

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqQ) |-> !regQ[SL_STATUS][ST_IE]); // R9

  AST_INDEX_TOP: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regQ[SL_INDEX][XLEN-1])); // R3

  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regQ[SL_CAUSE] & keepMask(SL_CAUSE))); // R3

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] PRID_VAL   = 32'h0001_8000,
  parameter logic [31:0] CFG0_RESET = 32'h8000_8080,
  parameter logic [31:0] CFG1_VAL   = 32'h1E19_0C8A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [4:0]  accReg,
  input  logic [2:0]  accSel,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [5:0]  irqLines,
  input  logic [31:0] randomVal,
  input  logic [31:0] countVal,
  input  logic [31:0] compareVal,
  input  logic [31:0] badVaddr,
  input  logic [31:0] llAddr,
  output logic        userMode,
  output logic        excLevel,
  output logic        errLevel,
  output logic        debugMode,
  output logic        hardIrq,
  output logic        flushReq
);

  strobe_t stb;

  sysctl_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .accReg (accReg),
    .accSel (accSel),
    .stb    (stb)
  );

  sysctl_dpath #(
    .PRID_VAL   (PRID_VAL),
    .CFG0_RESET (CFG0_RESET),
    .CFG1_VAL   (CFG1_VAL)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .irqLines   (irqLines),
    .randomVal  (randomVal),
    .countVal   (countVal),
    .compareVal (compareVal),
    .badVaddr   (badVaddr),
    .llAddr     (llAddr),
    .rdData     (rdData),
    .userMode   (userMode),
    .excLevel   (excLevel),
    .errLevel   (errLevel),
    .debugMode  (debugMode),
    .hardIrq    (hardIrq),
    .flushReq   (flushReq)
  );

endmodule

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

  localparam logic [31:0] PRID = 32'h0001_8000;
  localparam logic [31:0] CFG0 = 32'h8000_8080;
  localparam logic [31:0] CFG1 = 32'h1E19_0C8A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  accReg = '0;
  logic [2:0]  accSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [5:0]  irqLines = '0;
  logic [31:0] randomVal  = 32'h0000_000B;
  logic [31:0] countVal   = 32'h1122_3344;
  logic [31:0] compareVal = 32'h5566_7788;
  logic [31:0] badVaddr   = 32'hDEAD_BEEF;
  logic [31:0] llAddr     = 32'h1234_5670;
  logic userMode, excLevel, errLevel, debugMode, hardIrq, flushReq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sysctl_regfile #(.PRID_VAL(PRID), .CFG0_RESET(CFG0), .CFG1_VAL(CFG1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .accReg(accReg), .accSel(accSel),
    .wrData(wrData), .rdData(rdData), .irqLines(irqLines), .randomVal(randomVal),
    .countVal(countVal), .compareVal(compareVal), .badVaddr(badVaddr), .llAddr(llAddr),
    .userMode(userMode), .excLevel(excLevel), .errLevel(errLevel),
    .debugMode(debugMode), .hardIrq(hardIrq), .flushReq(flushReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive a move-to at a falling edge; returns at the next falling edge
  task automatic doWrite(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    accReg = r; accSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkRead(input string req, input logic [4:0] r, input logic [2:0] s,
                         input logic [31:0] exp);
    accReg = r; accSel = s;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic tReset;
    chkRead("R1 status", 5'd12, 3'd0, 32'h0);
    chkRead("R1 config", 5'd16, 3'd0, CFG0);
    chkRead("R1 index", 5'd0, 3'd0, 32'h0);
    chkRead("R1 entryhi", 5'd10, 3'd0, 32'h0);
    chk("R1 flags", {26'd0, userMode, excLevel, errLevel, debugMode, hardIrq, flushReq}, 32'h0);
  endtask

  task automatic tMasks;
    doWrite(5'd2, 3'd0, 32'hFFFF_FFFF);  chkRead("R2 entrylo0", 5'd2, 3'd0, 32'h3FFF_FFFF);
    doWrite(5'd3, 3'd0, 32'hFFFF_FFFF);  chkRead("R2 entrylo1", 5'd3, 3'd0, 32'h3FFF_FFFF);
    doWrite(5'd5, 3'd0, 32'hFFFF_FFFF);  chkRead("R2 pagemask", 5'd5, 3'd0, 32'h01FF_E000);
    doWrite(5'd6, 3'd0, 32'hFFFF_FFFF);  chkRead("R2 wired", 5'd6, 3'd0, 32'h0000_000F);
    doWrite(5'd19, 3'd0, 32'hFFFF_FFFF); chkRead("R2 watchhi", 5'd19, 3'd0, 32'h40FF_0FF8);
    doWrite(5'd28, 3'd0, 32'hFFFF_FFFF); chkRead("R2 taglo", 5'd28, 3'd0, 32'hFFFF_FCF6);
    doWrite(5'd10, 3'd0, 32'hFFFF_FFFF); chkRead("R2 entryhi", 5'd10, 3'd0, 32'hFFFF_E0FF);
    doWrite(5'd14, 3'd0, 32'hA5A5_5A5A); chkRead("R2 epc", 5'd14, 3'd0, 32'hA5A5_5A5A);
    doWrite(5'd31, 3'd0, 32'h1357_9BDF); chkRead("R2 desave", 5'd31, 3'd0, 32'h1357_9BDF);
  endtask

  task automatic tPreserve;
    doWrite(5'd0, 3'd0, 32'hFFFF_FFFF);  chkRead("R3 index", 5'd0, 3'd0, 32'h0000_000F);
    doWrite(5'd4, 3'd0, 32'hFFFF_FFFF);  chkRead("R3 context", 5'd4, 3'd0, 32'h007F_FFF0);
    doWrite(5'd13, 3'd0, 32'hFFFF_FFFF); chkRead("R3 cause sw", 5'd13, 3'd0, 32'h0000_0300);
    irqLines = 6'h21;                    chkRead("R3 cause hw", 5'd13, 3'd0, 32'h0000_8700);
    irqLines = 6'h00;
    doWrite(5'd13, 3'd0, 32'h0);         chkRead("R3 cause clr", 5'd13, 3'd0, 32'h0);
    doWrite(5'd16, 3'd0, 32'hFFFF_FFFF); chkRead("R3 config", 5'd16, 3'd0, 32'h8000_8081);
    doWrite(5'd16, 3'd0, 32'h0);         chkRead("R3 config clr", 5'd16, 3'd0, CFG0);
  endtask

  task automatic tSelect;
    doWrite(5'd14, 3'd1, 32'h0);         chkRead("R4 bad sel keeps", 5'd14, 3'd0, 32'hA5A5_5A5A);
    chkRead("R4 bad sel reads 0", 5'd14, 3'd1, 32'h0);
    chkRead("R4 cfg1", 5'd16, 3'd1, CFG1);
    doWrite(5'd16, 3'd1, 32'hFFFF_FFFF); chkRead("R4 cfg1 write", 5'd16, 3'd0, CFG0);
    chkRead("R4 cfg1 after", 5'd16, 3'd1, CFG1);
    chkRead("R4 sel2", 5'd16, 3'd2, 32'h0);
    doWrite(5'd28, 3'd1, 32'h0);         chkRead("R4 datalo write", 5'd28, 3'd0, 32'hFFFF_FCF6);
    chkRead("R4 datalo", 5'd28, 3'd1, 32'h0);
  endtask

  task automatic tUnimpl;
    doWrite(5'd7, 3'd0, 32'hFFFF_FFFF);  chkRead("R5 reg7", 5'd7, 3'd0, 32'h0);
    doWrite(5'd20, 3'd0, 32'hFFFF_FFFF); chkRead("R5 reg20", 5'd20, 3'd0, 32'h0);
    doWrite(5'd9, 3'd0, 32'h0);          chkRead("R5 count", 5'd9, 3'd0, 32'h1122_3344);
    chkRead("R5 random", 5'd1, 3'd0, 32'h0000_000B);
    chkRead("R5 badvaddr", 5'd8, 3'd0, 32'hDEAD_BEEF);
    chkRead("R5 compare", 5'd11, 3'd0, 32'h5566_7788);
    chkRead("R5 prid", 5'd15, 3'd0, PRID);
    chkRead("R5 lladdr", 5'd17, 3'd0, 32'h0123_4567);
  endtask

  task automatic tModes;
    doWrite(5'd12, 3'd0, 32'h0000_0017);
    chkRead("R6 status merge", 5'd12, 3'd0, 32'h0000_0017);
    chk("R6 flags", {29'd0, userMode, errLevel, excLevel}, 32'h7);
    chk("R8 no irq with exl", {31'd0, hardIrq}, 32'h0);
    doWrite(5'd12, 3'd0, 32'hFFFF_FFFF);
    chkRead("R6 status full", 5'd12, 3'd0, 32'hFA78_FF17);
    doWrite(5'd12, 3'd0, 32'h0);
    chkRead("R6 status clr", 5'd12, 3'd0, 32'h0);
    chk("R6 flags clr", {29'd0, userMode, errLevel, excLevel}, 32'h0);
  endtask

  task automatic tDebug;
    doWrite(5'd23, 3'd0, 32'hFFFF_FFFF);
    chkRead("R7 debug", 5'd23, 3'd0, 32'h5330_0120);
    chk("R7 dm set", {31'd0, debugMode}, 32'h1);
    doWrite(5'd23, 3'd0, 32'h0);
    chkRead("R7 debug clr", 5'd23, 3'd0, 32'h0);
    chk("R7 dm clr", {31'd0, debugMode}, 32'h0);
  endtask

  task automatic tIrq;
    doWrite(5'd13, 3'd0, 32'h0000_0300);
    doWrite(5'd12, 3'd0, 32'h0000_0100);
    chk("R8 no irq ie0", {31'd0, hardIrq}, 32'h0);
    doWrite(5'd12, 3'd0, 32'h0000_0101);
    chk("R8 irq raise", {31'd0, hardIrq}, 32'h1);
    doWrite(5'd12, 3'd0, 32'h0000_0101);
    chk("R9 irq hold", {31'd0, hardIrq}, 32'h1);
    doWrite(5'd12, 3'd0, 32'h0000_0100);
    chk("R9 irq drop", {31'd0, hardIrq}, 32'h0);
    doWrite(5'd12, 3'd0, 32'h0000_0001);
    chk("R8 masked", {31'd0, hardIrq}, 32'h0);
    doWrite(5'd12, 3'd0, 32'h0);
    doWrite(5'd23, 3'd0, 32'h4000_0000);
    doWrite(5'd12, 3'd0, 32'h0000_0100);
    doWrite(5'd12, 3'd0, 32'h0000_0101);
    chk("R8 no irq in debug", {31'd0, hardIrq}, 32'h0);
    doWrite(5'd23, 3'd0, 32'h0);
    doWrite(5'd12, 3'd0, 32'h0);
    doWrite(5'd13, 3'd0, 32'h0);
    irqLines = 6'h01;
    doWrite(5'd12, 3'd0, 32'h0000_0400);
    doWrite(5'd12, 3'd0, 32'h0000_0401);
    chk("R8 hw line raise", {31'd0, hardIrq}, 32'h1);
    doWrite(5'd12, 3'd0, 32'h0);
    chk("R9 hw line drop", {31'd0, hardIrq}, 32'h0);
    irqLines = 6'h00;
  endtask

  task automatic tFlush;
    doWrite(5'd10, 3'd0, 32'h0000_A0FF);
    chk("R10 same asid", {31'd0, flushReq}, 32'h0);
    doWrite(5'd10, 3'd0, 32'h0000_A012);
    chk("R10 asid change", {31'd0, flushReq}, 32'h1);
    @(negedge clk);
    chk("R10 one cycle", {31'd0, flushReq}, 32'h0);
    chkRead("R10 entryhi", 5'd10, 3'd0, 32'h0000_A012);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMasks();
    tPreserve();
    tSelect();
    tUnimpl();
    tModes();
    tDebug();
    tIrq();
    tFlush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule